// File: doc/BRIEF.md
# Two-Slot Fetch and Issue Stage with Per-Instruction Hold Bit

This block sits at the front of a statically scheduled two-way processor. Each cycle it can fetch one packet of two 40-bit instructions from the instruction cache and present them to two issue slots. Every instruction carries a hold bit. When the bit is set, the instruction waits one cycle before it issues. This lets the compiler insert a bubble without spending a whole word on an explicit empty instruction.

While a packet is being held or split, and while the machine is stalled, the stage keeps its cache read enable low. It also gates the register-file read enables and the enables of the downstream datapath latches. The instruction buses it drives keep their last issued value, so a bubble causes no switching downstream. A taken redirect discards the held packet and starts a fetch at the new address.

The issue side works as a valid/ready stream. `iss_fire` is the per-slot valid, and the stream is ready whenever `stall` is low. When `stall` is high nothing issues, nothing is read, and all internal state is kept, so issue resumes exactly where it stopped. The cache is a synchronous read that returns `ic_rdata` for `ic_addr` in the same cycle that `ic_rd_en` is high. The packet is captured at the following clock edge.

Top module: `dual_issue_fetch`

## Requirements
- R1: While reset is held, no slot fires and no latch or register-file enable is high. In the first cycle after reset, the cache is read at address 0.
- R2: A packet lives on `ic_rdata`. Slot 0 is bits 39:0 and slot 1 is bits 79:40. Within each instruction, bit 39 is the hold bit, bit 38 means source 1 is read, bit 37 means source 2 is read, and bit 36 means a result is written. If neither hold bit is set, both slots fire in the cycle after the packet is captured, and the next packet is read in that same cycle.
- R3: If only slot 0 has its hold bit set, the packet produces one cycle with no slot firing and no cache read, then both slots fire together.
- R4: If only slot 1 has its hold bit set, slot 0 fires alone, and slot 1 fires alone in the next active cycle. The next packet is read together with slot 1, so program order is kept.
- R5: If both hold bits are set, there is one empty cycle, then slot 0 alone, then slot 1 alone.
- R6: `ic_rd_en` is high only when the stage holds no packet, or when the last slot of the current packet fires. A held packet is never read a second time.
- R7: While `stall` is high (and no redirect), nothing fires, `ic_rd_en` is low, all enables are low, and fetch address and held packet are kept.
- R8: `rf_rd_en[2i]` equals slot i firing AND bit 38 of its instruction. `rf_rd_en[2i+1]` equals slot i firing AND bit 37.
- R9: `lat_en[i]` equals slot i firing AND bit 36 of its instruction.
- R10: In a cycle when slot i does not fire, its instruction bus keeps the value it last carried. Its reset value is 0.
- R11: A redirect takes precedence over a stall. In the redirect cycle nothing fires and nothing is read. The held packet is dropped, and the next unstalled cycle reads the redirect address.
- R12: Each fetch advances the fetch address by one packet, wrapping modulo 2^16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stall | input | 1 | Back-pressure from downstream; high means not ready |
| redirect_valid | input | 1 | Taken control transfer this cycle |
| redirect_addr | input | 16 | New packet address for the redirect |
| ic_rd_en | output | 1 | Instruction cache read enable |
| ic_addr | output | 16 | Packet address presented to the cache |
| ic_rdata | input | 80 | Packet returned by the cache in the read cycle |
| iss_fire | output | 2 | Per-slot issue valid |
| iss_instr0 | output | 40 | Slot 0 instruction bus |
| iss_instr1 | output | 40 | Slot 1 instruction bus |
| rf_rd_en | output | 4 | Register-file read enables, two per slot |
| lat_en | output | 2 | Downstream datapath latch enables, one per slot |

## Verification
The cache model derives each packet's hold bits from the low two bits of its address. A straight run of sequential packets therefore visits all four hold patterns in turn and separates the joint bubble (R3), the split issue (R4) and the double delay (R5) from plain dual issue (R2). A second pattern overlays an arithmetic stall sequence, so stalls land on every phase of each pattern. This shows whether a stall merely freezes a hold, or whether it wrongly consumes the hold or re-reads the cache. A third pattern adds redirects, some of them coinciding with stalls and some aimed just below the top of the address space. These show that a held packet is dropped, that the redirect outranks the stall, and that the fetch address wraps.

// File: rtl/dif_pkg.sv
package dif_pkg;

  localparam int unsigned SLOTS = 2;

  // Progress through one captured packet
  typedef enum logic [1:0] {
    PH_FRESH    = 2'd0,  // nothing of the packet issued yet
    PH_S0_READY = 2'd1,  // slot 0 hold served, slot 0 free to go
    PH_S1_READY = 2'd2   // slot 0 gone, slot 1 waiting its turn
  } phase_t;

endpackage

// File: rtl/dif_hold_ctrl.sv
module dif_hold_ctrl
  import dif_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       stall,
  input  logic       redirect,
  input  logic       ir_valid,
  input  logic [1:0] nop_bits,
  output logic [1:0] fire,
  output logic       fetch_req
);

  phase_t phase_q, phase_d;
  logic   pkt_done;

  always_comb begin
    fire     = 2'b00;
    pkt_done = 1'b0;
    phase_d  = phase_q;
    if (ir_valid && !stall && !redirect) begin
      case (phase_q)
        PH_FRESH: begin
          if (nop_bits[0]) begin
            phase_d = PH_S0_READY;
          end else if (nop_bits[1]) begin
            fire    = 2'b01;
            phase_d = PH_S1_READY;
          end else begin
            fire     = 2'b11;
            pkt_done = 1'b1;
          end
        end
        PH_S0_READY: begin
          if (nop_bits[1]) begin
            fire    = 2'b01;
            phase_d = PH_S1_READY;
          end else begin
            fire     = 2'b11;
            pkt_done = 1'b1;
          end
        end
        PH_S1_READY: begin
          fire     = 2'b10;
          pkt_done = 1'b1;
        end
        default: phase_d = PH_FRESH;
      endcase
    end
    if (pkt_done || redirect) phase_d = PH_FRESH;
    fetch_req = !redirect && !stall && (!ir_valid || pkt_done);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= PH_FRESH;
    else        phase_q <= phase_d;
  end

  // After slot 0 leaves alone, slot 0 cannot fire again next cycle
  assert_split_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fire == 2'b01) |=> !fire[0]);

  // A bubble is followed by slot 0 unless a stall or redirect intervenes
  assert_bubble_then_go_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ir_valid && !stall && !redirect && fire == 2'b00) |=> (fire[0] || stall || redirect));

  // A stall freezes packet progress
  assert_stall_freeze_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && !redirect) |=> $stable(phase_q));

endmodule

// File: rtl/dif_fetch_pc.sv
module dif_fetch_pc #(
  parameter int unsigned    AW         = 16,
  parameter logic [AW-1:0]  RESET_ADDR = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          redirect,
  input  logic [AW-1:0] redirect_addr,
  input  logic          fetch_req,
  output logic [AW-1:0] pc
);

  logic [AW-1:0] pc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         pc_q <= RESET_ADDR;
    else if (redirect)  pc_q <= redirect_addr;
    else if (fetch_req) pc_q <= pc_q + 1'b1;
  end

  assign pc = pc_q;

  assert_pc_step_R12: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_req |=> (pc_q == AW'($past(pc_q) + 1'b1)));

  assert_pc_redirect_R11: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |=> (pc_q == $past(redirect_addr)));

  assert_pc_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_seen && !redirect) |=> $stable(pc_q));

  // local copy of "no fetch and no redirect" for the hold check above
  logic stall_seen;
  assign stall_seen = !fetch_req;

endmodule

// File: rtl/dif_issue_buf.sv
module dif_issue_buf #(
  parameter int unsigned PW = 80
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          redirect,
  input  logic          fetch_req,
  input  logic [PW-1:0] rdata,
  output logic          ir_valid,
  output logic [PW-1:0] ir_pkt
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         ir_valid <= 1'b0;
    else if (redirect)  ir_valid <= 1'b0;
    else if (fetch_req) ir_valid <= 1'b1;
  end

  // Packet storage loads only on a real fetch: a hold never re-reads it
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         ir_pkt <= '0;
    else if (fetch_req) ir_pkt <= rdata;
  end

  assert_read_fills_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_req |=> ir_valid);

  assert_redirect_flush_R11: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |=> !ir_valid);

  assert_no_reload_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !fetch_req |=> $stable(ir_pkt));

endmodule

// File: rtl/dif_slot_gate.sv
module dif_slot_gate #(
  parameter int unsigned IW = 40
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fire,
  input  logic [IW-1:0] slot_word,
  output logic [IW-1:0] bus_out,
  output logic [1:0]    rf_en,
  output logic          lat_en
);

  localparam int unsigned RS1_POS = IW - 2;
  localparam int unsigned RS2_POS = IW - 3;
  localparam int unsigned WR_POS  = IW - 4;

  logic [IW-1:0] last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    last_q <= '0;
    else if (fire) last_q <= slot_word;
  end

  // Bus keeps its previous value unless this slot fires
  assign bus_out  = fire ? slot_word : last_q;
  assign rf_en[0] = fire & slot_word[RS1_POS];
  assign rf_en[1] = fire & slot_word[RS2_POS];
  assign lat_en   = fire & slot_word[WR_POS];

  assert_bus_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |-> $stable(bus_out));

endmodule

// File: rtl/dual_issue_fetch.sv
module dual_issue_fetch
  import dif_pkg::*;
#(
  parameter int unsigned   AW         = 16,
  parameter int unsigned   IW         = 40,
  parameter logic [AW-1:0] RESET_ADDR = '0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                stall,
  input  logic                redirect_valid,
  input  logic [AW-1:0]       redirect_addr,
  output logic                ic_rd_en,
  output logic [AW-1:0]       ic_addr,
  input  logic [SLOTS*IW-1:0] ic_rdata,
  output logic [SLOTS-1:0]    iss_fire,
  output logic [IW-1:0]       iss_instr0,
  output logic [IW-1:0]       iss_instr1,
  output logic [2*SLOTS-1:0]  rf_rd_en,
  output logic [SLOTS-1:0]    lat_en
);

  localparam int unsigned PW      = SLOTS * IW;
  localparam int unsigned NOP_POS = IW - 1;

  logic             fetch_req;
  logic             ir_valid;
  logic [PW-1:0]    ir_pkt;
  logic [SLOTS-1:0] nop_bits;
  logic [SLOTS-1:0] fire;
  logic [IW-1:0]    bus_w [SLOTS];

  dif_fetch_pc #(.AW(AW), .RESET_ADDR(RESET_ADDR)) u_pc (
    .clk          (clk),
    .rst_n        (rst_n),
    .redirect     (redirect_valid),
    .redirect_addr(redirect_addr),
    .fetch_req    (fetch_req),
    .pc           (ic_addr)
  );

  dif_issue_buf #(.PW(PW)) u_buf (
    .clk      (clk),
    .rst_n    (rst_n),
    .redirect (redirect_valid),
    .fetch_req(fetch_req),
    .rdata    (ic_rdata),
    .ir_valid (ir_valid),
    .ir_pkt   (ir_pkt)
  );

  for (genvar s = 0; s < SLOTS; s++) begin : g_nop
    assign nop_bits[s] = ir_pkt[s*IW + NOP_POS];
  end

  dif_hold_ctrl u_ctl (
    .clk      (clk),
    .rst_n    (rst_n),
    .stall    (stall),
    .redirect (redirect_valid),
    .ir_valid (ir_valid),
    .nop_bits (nop_bits),
    .fire     (fire),
    .fetch_req(fetch_req)
  );

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    dif_slot_gate #(.IW(IW)) u_gate (
      .clk      (clk),
      .rst_n    (rst_n),
      .fire     (fire[s]),
      .slot_word(ir_pkt[s*IW +: IW]),
      .bus_out  (bus_w[s]),
      .rf_en    (rf_rd_en[2*s +: 2]),
      .lat_en   (lat_en[s])
    );
  end

  assign ic_rd_en   = fetch_req;
  assign iss_fire   = fire;
  assign iss_instr0 = bus_w[0];
  assign iss_instr1 = bus_w[1];

  assert_stall_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && !redirect_valid) |-> (!ic_rd_en && iss_fire == '0));

endmodule

// File: tb/tb_dual_issue_fetch.sv
`timescale 1ns/1ps
module tb_dual_issue_fetch;

  localparam int AW = 16;
  localparam int IW = 40;
  localparam int NCYC = 1500;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          stall = 1'b0;
  logic          redirect_valid = 1'b0;
  logic [AW-1:0] redirect_addr = '0;
  logic          ic_rd_en;
  logic [AW-1:0] ic_addr;
  logic [2*IW-1:0] ic_rdata;
  logic [1:0]    iss_fire;
  logic [IW-1:0] iss_instr0, iss_instr1;
  logic [3:0]    rf_rd_en;
  logic [1:0]    lat_en;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #10 clk = ~clk;

  function automatic logic [2*IW-1:0] mkpkt(input logic [AW-1:0] a);
    logic [IW-1:0] w0, w1;
    w0 = {a[0], a[2], a[3],  a[4], 20'h5A5A5, a};
    w1 = {a[1], a[5], a[2], ~a[3], 20'hC3C3C, a};
    return {w1, w0};
  endfunction

  assign ic_rdata = mkpkt(ic_addr);

  dual_issue_fetch dut (
    .clk(clk), .rst_n(rst_n), .stall(stall),
    .redirect_valid(redirect_valid), .redirect_addr(redirect_addr),
    .ic_rd_en(ic_rd_en), .ic_addr(ic_addr), .ic_rdata(ic_rdata),
    .iss_fire(iss_fire), .iss_instr0(iss_instr0), .iss_instr1(iss_instr1),
    .rf_rd_en(rf_rd_en), .lat_en(lat_en)
  );

  task automatic chk(input string tag, input logic [79:0] act, input logic [79:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Expected fire mask at step k of a packet whose hold bits are a[1:0]
  function automatic logic [1:0] efire(input logic [AW-1:0] a, input int k);
    case ({a[1], a[0]})
      2'b00:   return 2'b11;
      2'b01:   return (k == 0) ? 2'b00 : 2'b11;
      2'b10:   return (k == 0) ? 2'b01 : 2'b10;
      default: return (k == 0) ? 2'b00 : ((k == 1) ? 2'b01 : 2'b10);
    endcase
  endfunction

  // Reference state
  logic          m_valid = 1'b0;
  logic [AW-1:0] m_pc = '0;
  logic [AW-1:0] m_a = '0;
  int            m_k = 0;
  logic [IW-1:0] last0 = '0, last1 = '0;
  bit            first = 1'b1;

  task automatic step(input logic s, input logic r, input logic [AW-1:0] ra);
    logic [1:0] e_fire;
    logic e_rd, lastk;
    logic [IW-1:0] w0, w1, e_i0, e_i1;
    logic [3:0] e_rf;
    logic [1:0] e_lat;
    string ftag, rtag;
    int dur;
    @(negedge clk);
    rst_n = 1'b1;
    stall = s; redirect_valid = r; redirect_addr = ra;
    {w1, w0} = mkpkt(m_a);
    dur = 1 + int'(m_a[0]) + int'(m_a[1]);
    e_fire = 2'b00; e_rd = 1'b0; lastk = 1'b0;
    case ({m_a[1], m_a[0]})
      2'b00: ftag = "R2";
      2'b01: ftag = "R3";
      2'b10: ftag = "R4";
      default: ftag = "R5";
    endcase
    rtag = "R6";
    if (r) begin
      ftag = "R11"; rtag = "R11";
    end else if (s) begin
      ftag = "R7"; rtag = "R7";
    end else if (!m_valid) begin
      e_rd = 1'b1;
    end else begin
      e_fire = efire(m_a, m_k);
      lastk  = (m_k == dur - 1);
      e_rd   = lastk;
    end
    if (first) rtag = "R1";
    e_i0  = e_fire[0] ? w0 : last0;
    e_i1  = e_fire[1] ? w1 : last1;
    e_rf  = {e_fire[1] & w1[37], e_fire[1] & w1[38], e_fire[0] & w0[37], e_fire[0] & w0[38]};
    e_lat = {e_fire[1] & w1[36], e_fire[0] & w0[36]};
    #1;
    chk(ftag,  80'(iss_fire), 80'(e_fire));
    chk(rtag,  80'(ic_rd_en), 80'(e_rd));
    if (e_rd) chk("R12", 80'(ic_addr), 80'(m_pc));
    chk("R8",  80'(rf_rd_en), 80'(e_rf));
    chk("R9",  80'(lat_en), 80'(e_lat));
    chk("R10", 80'(iss_instr0), 80'(e_i0));
    chk("R10", 80'(iss_instr1), 80'(e_i1));
    // advance reference
    if (r) begin
      m_valid = 1'b0; m_pc = ra; m_k = 0;
    end else if (!s) begin
      if (e_rd) begin
        m_valid = 1'b1; m_a = m_pc; m_pc = m_pc + 1'b1; m_k = 0;
      end else begin
        m_k++;
      end
    end
    if (e_fire[0]) last0 = w0;
    if (e_fire[1]) last1 = w1;
    first = 1'b0;
  endtask

  initial begin
    // R1: outputs quiet while reset held
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      #1;
      chk("R1", 80'(iss_fire), 80'd0);
      chk("R1", 80'(lat_en), 80'd0);
      chk("R1", 80'(rf_rd_en), 80'd0);
      chk("R1", 80'(iss_instr0), 80'd0);
    end
    for (int c = 0; c < NCYC; c++) begin
      logic s, r;
      logic [AW-1:0] ra;
      s  = ((c >= 100) && (((c * 7 + 3) % 11) < 3)) || (c >= 300 && c < 310);
      r  = (c >= 400) && (c % 17 == 5);
      ra = (c % 34 == 5) ? AW'(16'hFFFC + (c % 3)) : AW'(c * 37);
      step(s, r, ra);
    end
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule